// File: doc/BRIEF.md
# SPI Queue Bus Front-End

This block sits between a simple single-cycle bus slave port and a slot-based SPI engine. It gives software three regions in its address space. The first is a 4 KB transmit window: a write there pushes the written word into a transmit queue. The word carries a slot number taken from the word offset of the address, so the address alone picks the target chip select and its configuration. The second is a 4 KB receive window: a read there pops the receive queue. The third is a small register region that holds the queue controls and status, two latched events and an interrupt mask.

Software works in a fire-and-forget style. It writes words to the slot addresses and can then leave. It comes back on an interrupt, or when it sees a status level, and reads the results in order. The SPI engine is not part of this block. It takes `{slot, data}` from a valid/ready output stream and returns result words on a valid/ready input stream.

The address map is chosen by `bus_addr[13:12]`: 0 is the transmit window, 1 is the receive window and 2 is the register region. In the register region the word index `bus_addr[4:2]` selects the register:

| Index | Register |
|---|---|
| 0 | TX control |
| 1 | TX status |
| 2 | RX control |
| 3 | RX status |
| 4 | event pending |
| 5 | event enable |

Both control registers use the same layout: enable at bit 0 and a threshold at bits 16 and up. A read returns its data on `bus_rdata` at the clock edge that follows the read request.

Top module: `spi_mmio_queue`

## Requirements
- R1: After reset:
  - both status registers read 0x00000002, that is empty only;
  - `irq` is 0, `tx_valid` is 0 and `rx_ready` is 0, because both enables reset to 0.
- R2: A write into the transmit window queues one entry. Its slot is the word offset `bus_addr[3:2]` taken modulo NUM_SLOTS (4). Its data is `bus_wdata` with every byte lane whose `bus_be` bit is 0 forced to zero. For example, a byte write of 0x..5A with `bus_be`=0001 at offset 4 queues slot 1 with data 0x0000005A.
- R3: Transmit entries leave on `tx_slot`/`tx_data` in write order, including repeated writes to the same slot. The head entry stays unchanged while `tx_valid` is high and `tx_ready` is low.
- R4: The bits of a status register are:
  - bit 0, ongoing: in TX this is `eng_busy` OR `tx_valid`, in RX it is `eng_busy`;
  - bit 1, empty;
  - bit 2, full;
  - bit 3, TX only: the overflow flag;
  - bits 16 and up: the queue level.
- R5: A transmit write while the queue holds 32 entries is dropped and sets the sticky overflow flag. The level stays at 32. Writing 1 to bit 3 of TX status clears the flag.
- R6: Each read of the receive window returns the oldest result and lowers the RX level by one. A read while the queue is empty returns 0 and leaves the level at 0.
- R7: While TX enable is 0, `tx_valid` stays 0 and entries remain queued. While RX enable is 0, `rx_ready` stays 0.
- R8: Pending bit 0 (TX done) is set when a transmit pop leaves the TX level at or below the TX threshold.
- R9: Pending bit 1 (RX data) is set when a receive push leaves the RX level above the RX threshold.
- R10: Writing the pending register clears each pending bit written as 1. A bit being set in the same cycle wins.
- R11: `irq` is 1 exactly when some pending bit has its event enable bit set.
- R12: `rx_ready` is 0 while the receive queue holds 32 entries. A result offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access request, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 14 | Byte address |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_valid | output | 1 | Transmit entry available |
| tx_ready | input | 1 | Engine takes the entry |
| tx_slot | output | 2 | Slot of the head entry |
| tx_data | output | 32 | Data of the head entry |
| rx_valid | input | 1 | Engine offers a result |
| rx_ready | output | 1 | Result accepted |
| rx_data | input | 32 | Result word |
| eng_busy | input | 1 | Engine is mid-transfer |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the block with its defaults: 32-bit data, 32-entry queues and four slots. With a queue depth of 32, both the full boundary and the overflow drop are reached within a few hundred cycles. With four slots, the word offsets 4 and 255 alias back onto slots 0 and 3, so the modulo slot decode is exercised next to the plain offsets. A threshold of 0 on transmit and 1 on receive places both event edges at a known entry, the last pop and the second push.

// File: rtl/spi_mq_pkg.sv
package spi_mq_pkg;

   localparam logic [1:0] RG_TXWIN = 2'd0;
   localparam logic [1:0] RG_RXWIN = 2'd1;
   localparam logic [1:0] RG_CSR   = 2'd2;

   localparam logic [2:0] CSR_TXCTRL = 3'd0;
   localparam logic [2:0] CSR_TXSTAT = 3'd1;
   localparam logic [2:0] CSR_RXCTRL = 3'd2;
   localparam logic [2:0] CSR_RXSTAT = 3'd3;
   localparam logic [2:0] CSR_EVPEND = 3'd4;
   localparam logic [2:0] CSR_EVEN   = 3'd5;

   localparam int unsigned ST_ONGOING = 0;
   localparam int unsigned ST_EMPTY   = 1;
   localparam int unsigned ST_FULL    = 2;
   localparam int unsigned ST_OVF     = 3;
   localparam int unsigned FLD_LSB    = 16;

   localparam int unsigned EV_TX  = 0;
   localparam int unsigned EV_RX  = 1;
   localparam int unsigned NUM_EV = 2;

endpackage

// File: rtl/spi_mq_fifo.sv
module spi_mq_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty,
   output logic [LVL_W-1:0] level
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("spi_mq_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (level == LVL_W'(DEPTH)));

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (level == '0));

   assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

endmodule

// File: rtl/spi_mq_events.sv
module spi_mq_events #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev_set,
   input  logic         pend_wr,
   input  logic         mask_wr,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] pending,
   output logic [N-1:0] enable,
   output logic         irq
);

   logic [N-1:0] clr;
   assign clr = pend_wr ? wbits : '0;

   for (genvar i = 0; i < N; i++) begin : g_ev
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         pending[i] <= 1'b0;
         else if (ev_set[i]) pending[i] <= 1'b1;
         else if (clr[i])    pending[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       enable[i] <= 1'b0;
         else if (mask_wr) enable[i] <= wbits[i];
      end

      assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !ev_set[i]) |=> !pending[i]);

      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ev_set[i] |=> pending[i]);
   end

   assign irq = |(pending & enable);

endmodule

// File: rtl/spi_mq_decode.sv
module spi_mq_decode
   import spi_mq_pkg::*;
#(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned SLOT_W = 2
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              tx_wr,
   output logic              rx_rd,
   output logic              csr_wr,
   output logic              csr_rd,
   output logic [2:0]        csr_idx,
   output logic [SLOT_W-1:0] slot
);

   logic [1:0] region;
   assign region  = bus_addr[ADDR_W-1 -: 2];
   assign slot    = bus_addr[2 +: SLOT_W];
   assign csr_idx = bus_addr[4:2];

   assign tx_wr  = bus_valid &&  bus_write && (region == RG_TXWIN);
   assign rx_rd  = bus_valid && !bus_write && (region == RG_RXWIN);
   assign csr_wr = bus_valid &&  bus_write && (region == RG_CSR);
   assign csr_rd = bus_valid && !bus_write && (region == RG_CSR);

   logic unused_addr;
   assign unused_addr = ^bus_addr;

endmodule

// File: rtl/spi_mmio_queue.sv
module spi_mmio_queue
   import spi_mq_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned WIN_W     = 12,
   localparam int unsigned ADDR_W = WIN_W + 2,
   localparam int unsigned BE_W   = DATA_W / 8,
   localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
   localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
   localparam int unsigned TXW    = SLOT_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [SLOT_W-1:0] tx_slot,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              eng_busy,
   output logic              irq
);

   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be whole bytes");
      assert (DATA_W >= FLD_LSB + LVL_W) else $error("DATA_W too narrow for level field");
      assert (NUM_SLOTS >= 2 && (NUM_SLOTS & (NUM_SLOTS - 1)) == 0)
         else $error("NUM_SLOTS must be a power of two >= 2");
      assert (WIN_W >= SLOT_W + 3) else $error("window too small for slot and CSR decode");
   end

   // ---------------- decode
   logic              dec_tx_wr, dec_rx_rd, dec_csr_wr, dec_csr_rd;
   logic [2:0]        dec_idx;
   logic [SLOT_W-1:0] dec_slot;

   spi_mq_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) i_decode (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .tx_wr     (dec_tx_wr),
      .rx_rd     (dec_rx_rd),
      .csr_wr    (dec_csr_wr),
      .csr_rd    (dec_csr_rd),
      .csr_idx   (dec_idx),
      .slot      (dec_slot)
   );

   // ---------------- byte lane masking
   logic [DATA_W-1:0] lane_mask;
   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{bus_be[b]}};
   end

   // ---------------- control registers
   logic             tx_en, rx_en, tx_ovf;
   logic [LVL_W-1:0] tx_thr, rx_thr;
   logic             wr_txctrl, wr_txstat, wr_rxctrl, wr_evpend, wr_even;

   assign wr_txctrl = dec_csr_wr && (dec_idx == CSR_TXCTRL);
   assign wr_txstat = dec_csr_wr && (dec_idx == CSR_TXSTAT);
   assign wr_rxctrl = dec_csr_wr && (dec_idx == CSR_RXCTRL);
   assign wr_evpend = dec_csr_wr && (dec_idx == CSR_EVPEND);
   assign wr_even   = dec_csr_wr && (dec_idx == CSR_EVEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en  <= 1'b0;
         tx_thr <= '0;
         rx_en  <= 1'b0;
         rx_thr <= '0;
      end else begin
         if (wr_txctrl) begin
            tx_en  <= bus_wdata[0];
            tx_thr <= bus_wdata[FLD_LSB +: LVL_W];
         end
         if (wr_rxctrl) begin
            rx_en  <= bus_wdata[0];
            rx_thr <= bus_wdata[FLD_LSB +: LVL_W];
         end
      end
   end

   // ---------------- transmit queue
   logic             tx_full, tx_empty, tx_pop;
   logic [LVL_W-1:0] tx_level;
   logic [TXW-1:0]   tx_head;
   logic             ovf_clear;

   spi_mq_fifo #(.WIDTH(TXW), .DEPTH(DEPTH)) i_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (dec_tx_wr),
      .din   ({dec_slot, bus_wdata & lane_mask}),
      .pop   (tx_pop),
      .dout  (tx_head),
      .full  (tx_full),
      .empty (tx_empty),
      .level (tx_level)
   );

   assign tx_valid = tx_en && !tx_empty;
   assign tx_pop   = tx_valid && tx_ready;
   assign {tx_slot, tx_data} = tx_head;

   assign ovf_clear = wr_txstat && bus_wdata[ST_OVF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tx_ovf <= 1'b0;
      else if (dec_tx_wr && tx_full) tx_ovf <= 1'b1;
      else if (ovf_clear)            tx_ovf <= 1'b0;
   end

   // ---------------- receive queue
   logic              rx_full, rx_empty, rx_push, rx_pop;
   logic [LVL_W-1:0]  rx_level;
   logic [DATA_W-1:0] rx_head;

   assign rx_ready = rx_en && !rx_full;
   assign rx_push  = rx_valid && rx_ready;
   assign rx_pop   = dec_rx_rd;

   spi_mq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .din   (rx_data),
      .pop   (rx_pop),
      .dout  (rx_head),
      .full  (rx_full),
      .empty (rx_empty),
      .level (rx_level)
   );

   // ---------------- events: judged on the level one cycle after the move
   logic              tx_pop_q, rx_push_q;
   logic [NUM_EV-1:0] ev_set, ev_pend, ev_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_pop_q  <= 1'b0;
         rx_push_q <= 1'b0;
      end else begin
         tx_pop_q  <= tx_pop;
         rx_push_q <= rx_push;
      end
   end

   assign ev_set[EV_TX] = tx_pop_q  && (tx_level <= tx_thr);
   assign ev_set[EV_RX] = rx_push_q && (rx_level >  rx_thr);

   spi_mq_events #(.N(NUM_EV)) i_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_set  (ev_set),
      .pend_wr (wr_evpend),
      .mask_wr (wr_even),
      .wbits   (bus_wdata[NUM_EV-1:0]),
      .pending (ev_pend),
      .enable  (ev_en),
      .irq     (irq)
   );

   // ---------------- read path
   function automatic logic [DATA_W-1:0] pack_stat(
      input logic ong, input logic emp, input logic ful,
      input logic ovf, input logic [LVL_W-1:0] lvl);
      logic [DATA_W-1:0] s;
      s                   = '0;
      s[ST_ONGOING]       = ong;
      s[ST_EMPTY]         = emp;
      s[ST_FULL]          = ful;
      s[ST_OVF]           = ovf;
      s[FLD_LSB +: LVL_W] = lvl;
      return s;
   endfunction

   function automatic logic [DATA_W-1:0] pack_ctrl(
      input logic en, input logic [LVL_W-1:0] thr);
      logic [DATA_W-1:0] s;
      s                   = '0;
      s[0]                = en;
      s[FLD_LSB +: LVL_W] = thr;
      return s;
   endfunction

   logic [DATA_W-1:0] csr_rdata;

   always_comb begin
      case (dec_idx)
         CSR_TXCTRL: csr_rdata = pack_ctrl(tx_en, tx_thr);
         CSR_TXSTAT: csr_rdata = pack_stat(eng_busy | tx_valid, tx_empty, tx_full, tx_ovf, tx_level);
         CSR_RXCTRL: csr_rdata = pack_ctrl(rx_en, rx_thr);
         CSR_RXSTAT: csr_rdata = pack_stat(eng_busy, rx_empty, rx_full, 1'b0, rx_level);
         CSR_EVPEND: csr_rdata = DATA_W'(ev_pend);
         CSR_EVEN:   csr_rdata = DATA_W'(ev_en);
         default:    csr_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bus_rdata <= '0;
      else if (dec_rx_rd)  bus_rdata <= rx_empty ? '0 : rx_head;
      else if (dec_csr_rd) bus_rdata <= csr_rdata;
      else if (bus_valid && !bus_write) bus_rdata <= '0;
   end

   // ---------------- assertions
   assert_tx_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (!tx_valid || ($stable(tx_data) && $stable(tx_slot))));

   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !ovf_clear) |=> tx_ovf);

   assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_rx_rd && rx_empty) |=> (bus_rdata == '0));

   assert_tx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !tx_empty) |=> ($past(tx_en) || !tx_valid || tx_en));

   assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_en == '0) |-> !irq);

endmodule

// File: tb/test_spi_mmio_queue.sv
module test_spi_mmio_queue;

   localparam int DW = 32;
   localparam int NT = 8;

   localparam logic [13:0] A_TXCTRL = 14'h2000;
   localparam logic [13:0] A_TXSTAT = 14'h2004;
   localparam logic [13:0] A_RXCTRL = 14'h2008;
   localparam logic [13:0] A_RXSTAT = 14'h200C;
   localparam logic [13:0] A_EVPEND = 14'h2010;
   localparam logic [13:0] A_EVEN   = 14'h2014;
   localparam logic [13:0] A_RXWIN  = 14'h1000;

   localparam logic [13:0] T_ADDR [NT] = '{14'h000, 14'h004, 14'h008, 14'h00C,
                                           14'h000, 14'h000, 14'h010, 14'h3FC};
   localparam logic [3:0]  T_BE   [NT] = '{4'b0001, 4'b0001, 4'b0011, 4'b1111,
                                           4'b1111, 4'b1111, 4'b1111, 4'b1100};
   localparam logic [31:0] T_WD   [NT] = '{32'hFFFF_FF5A, 32'h0000_0001, 32'hABCD_5AA5, 32'h0102_0304,
                                           32'h0000_0001, 32'h0000_0002, 32'h1234_5678, 32'hDEAD_BEEF};
   localparam logic [1:0]  T_SLOT [NT] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0, 2'd3};
   localparam logic [31:0] T_EXP  [NT] = '{32'h0000_005A, 32'h0000_0001, 32'h0000_5AA5, 32'h0102_0304,
                                           32'h0000_0001, 32'h0000_0002, 32'h1234_5678, 32'hDEAD_0000};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [13:0]   bus_addr = '0;
   logic [3:0]    bus_be = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          tx_valid, tx_ready = 1'b0;
   logic [1:0]    tx_slot;
   logic [DW-1:0] tx_data;
   logic          rx_valid = 1'b0, rx_ready;
   logic [DW-1:0] rx_data = '0;
   logic          eng_busy = 1'b0;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   spi_mmio_queue i_spi_mmio_queue (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_slot(tx_slot), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .eng_busy(eng_busy), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bwr(input logic [13:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic brd(input logic [13:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rxpush(input logic [31:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      brd(A_TXSTAT, v); chk("R1 tx status", v, 32'h0000_0002);
      brd(A_RXSTAT, v); chk("R1 rx status", v, 32'h0000_0002);
      chk("R1 irq", irq, 1'b0);
      chk("R1 tx_valid", tx_valid, 1'b0);
      chk("R1 rx_ready", rx_ready, 1'b0);

      // R2 / R3 table walk: enable TX, threshold 0
      bwr(A_TXCTRL, 4'hF, 32'h0000_0001);
      for (int i = 0; i < NT; i++) bwr(T_ADDR[i], T_BE[i], T_WD[i]);
      brd(A_TXSTAT, v); chk("R4 tx status level 8 ongoing", v, 32'h0008_0001);
      for (int i = 0; i < NT; i++) begin
         @(negedge clk);
         chk("R3 tx_valid", tx_valid, 1'b1);
         chk($sformatf("R2 slot entry %0d", i), tx_slot, T_SLOT[i]);
         chk($sformatf("R3 data entry %0d", i), tx_data, T_EXP[i]);
         tx_ready = 1'b1;
         @(negedge clk);
         tx_ready = 1'b0;
      end
      brd(A_TXSTAT, v); chk("R4 tx status drained", v, 32'h0000_0002);

      // R8 / R11 / R10 events
      brd(A_EVPEND, v); chk("R8 tx event pending", v, 32'h1);
      chk("R11 irq masked", irq, 1'b0);
      bwr(A_EVEN, 4'hF, 32'h3);
      @(negedge clk); chk("R11 irq unmasked", irq, 1'b1);
      bwr(A_EVPEND, 4'hF, 32'h1);
      brd(A_EVPEND, v); chk("R10 pending cleared", v, 32'h0);
      chk("R11 irq after clear", irq, 1'b0);

      // R7 TX disabled holds data
      bwr(A_TXCTRL, 4'hF, 32'h0000_0000);
      bwr(14'h004, 4'hF, 32'hCAFE_0001);
      tx_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 tx_valid gated", tx_valid, 1'b0);
      tx_ready = 1'b0;
      brd(A_TXSTAT, v); chk("R7 tx kept queued", v, 32'h0001_0000);

      // R5 overflow
      for (int i = 0; i < 31; i++) bwr(14'h000, 4'hF, 32'h100 + i);
      brd(A_TXSTAT, v); chk("R4 tx full", v, 32'h0020_0004);
      bwr(14'h008, 4'hF, 32'hBAD0_BAD0);
      brd(A_TXSTAT, v); chk("R5 overflow sticky", v, 32'h0020_000C);
      bwr(A_TXSTAT, 4'hF, 32'h8);
      brd(A_TXSTAT, v); chk("R5 overflow cleared", v, 32'h0020_0004);
      bwr(A_TXCTRL, 4'hF, 32'h0000_0001);
      @(negedge clk);
      chk("R7 head after enable", tx_data, 32'hCAFE_0001);
      chk("R2 head slot", tx_slot, 2'd1);
      tx_ready = 1'b1;
      repeat (32) @(negedge clk);
      tx_ready = 1'b0;
      chk("R5 dropped word absent", tx_valid, 1'b0);
      brd(A_TXSTAT, v); chk("R4 tx empty again", v, 32'h0000_0002);
      bwr(A_EVPEND, 4'hF, 32'h3);

      // R9 / R6 receive
      bwr(A_RXCTRL, 4'hF, 32'h0001_0001);
      @(negedge clk); chk("R7 rx_ready enabled", rx_ready, 1'b1);
      rxpush(32'hA1);
      brd(A_EVPEND, v); chk("R9 no rx event at level 1", v, 32'h0);
      rxpush(32'hA2);
      brd(A_EVPEND, v); chk("R9 rx event at level 2", v, 32'h2);
      chk("R11 irq on rx", irq, 1'b1);
      rxpush(32'hA3);
      brd(A_RXSTAT, v); chk("R4 rx level 3", v, 32'h0003_0000);
      brd(A_RXWIN, v); chk("R6 rx pop 1", v, 32'hA1);
      brd(A_RXSTAT, v); chk("R6 rx level 2", v, 32'h0002_0000);
      brd(A_RXWIN, v); chk("R6 rx pop 2", v, 32'hA2);
      brd(A_RXWIN, v); chk("R6 rx pop 3", v, 32'hA3);
      brd(A_RXSTAT, v); chk("R6 rx drained", v, 32'h0000_0002);
      brd(A_RXWIN, v); chk("R6 empty read zero", v, 32'h0);
      brd(A_RXSTAT, v); chk("R6 level stays 0", v, 32'h0000_0002);
      bwr(A_EVPEND, 4'hF, 32'h2);
      @(negedge clk); chk("R10 irq cleared", irq, 1'b0);

      // R4 ongoing follows engine busy
      eng_busy = 1'b1;
      brd(A_RXSTAT, v); chk("R4 rx ongoing", v, 32'h0000_0003);
      eng_busy = 1'b0;

      // R12 receive full
      for (int i = 0; i < 32; i++) rxpush(32'h200 + i);
      @(negedge clk); chk("R12 rx_ready low when full", rx_ready, 1'b0);
      rxpush(32'hDEAD_DEAD);
      brd(A_RXSTAT, v); chk("R12 rx full level", v, 32'h0020_0004);
      brd(A_RXWIN, v); chk("R12 oldest kept", v, 32'h200);

      // R7 RX disabled
      bwr(A_RXCTRL, 4'hF, 32'h0);
      @(negedge clk); chk("R7 rx_ready disabled", rx_ready, 1'b0);

      finish_run();
   end

endmodule